// File: doc/BRIEF.md
# Channel-Partitioned Audio Transmit FIFO

This block sits between a 32-bit register port and an audio serializer. Software writes samples into a data register. The serializer takes them back out, one sample per pop strobe, in the order they were written. The sample store has a fixed size. The number of whole frames it may hold depends on the channel count taken from the format setting, so that more channels give fewer frames.

Software reads a status register to see how many complete frames are waiting. The same register carries sticky overflow and underflow flags and a pending bit for the half-level request. A control register gives software a self-clearing FIFO clear bit and an enable for the half-level interrupt. The interrupt line fires when the FIFO drains from above half of its capacity to half or below. It stays high until software acknowledges it.

Top module: `audio_tx_fifo`

## Requirements
- R1: The `chan_m1` input gives the channel count minus one. The FIFO accepts samples up to a frame limit, then reports full. The limit is 256 frames for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8.
- R2: A read of STATUS (offset 0x4) returns, in bits [16:8], the number of complete frames held, which is the samples held divided by the channel count and rounded down. Bits not named in R2 and R4 to R8 read as zero.
- R3: A write to DATA (offset 0x8) stores the low 24 bits of the write data. The upper bits are discarded. Each `ser_pop` on a non-empty FIFO puts the oldest sample on `ser_data` one cycle later, in write order.
- R4: A DATA write while the FIFO is full is dropped, and STATUS bit 4 (overflow) is set.
- R5: A `ser_pop` on an empty FIFO sets STATUS bit 0 (underflow). It leaves `ser_data` and the level unchanged.
- R6: The overflow, underflow and half-pending flags are sticky. A STATUS write clears each flag whose bit is written as 0 and keeps each flag whose bit is written as 1. A new event in the same cycle wins over the clear.
- R7: Writing CTRL (offset 0x0) with bit 0 set makes that bit read 1 for exactly one cycle. In that cycle the FIFO is emptied, and any DATA write or pop in that cycle is ignored. The sticky flags are kept.
- R8: CTRL bit 20 enables the half-level request. When it is enabled, the held sample count can fall from above half of the current capacity to half or below. One cycle after that change, STATUS bit 2 and `irq` go high. They stay high until a STATUS write with bit 2 at 0.
- R9: A register read returns its data on `reg_rdata` one cycle after `reg_rd`. CTRL reads back bits 20 and 0. DATA and unmapped offsets read as zero. After reset, all registers and `irq` are zero.
- R10: A DATA write and a pop in the same cycle, on a FIFO that is neither full nor empty, leave the frame count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| chan_m1 | input | 3 | Channel count minus one |
| ser_pop | input | 1 | Serializer pop strobe |
| ser_data | output | 24 | Sample popped last |
| irq | output | 1 | Half-level interrupt request |

## Verification
The FIFO is filled to its limit under four channel counts: 1, 3, 8 and 5. These show whether the frame limit and the capacity follow the count, including the odd counts where capacity is not a power of two. Partial frames, made by writing 5 and then 6 samples at 3 channels, show whether the residue rounds down. A full drain with the interrupt enabled separates the crossing event from the level itself. Writes with junk upper bits test the 24-bit mask. Simultaneous push and pop, pops on an empty FIFO, and data writes during the clear cycle probe the ordering rules. A behavioural queue model is compared against `irq`, `ser_data` and every read on every clock.

// File: rtl/audio_tx_fifo_pkg.sv
package audio_tx_fifo_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_DATA = 'h8;
  // control bits
  localparam int CTRL_CLR     = 0;
  localparam int CTRL_HALF_EN = 20;
  // status bits
  localparam int ST_UNF     = 0;
  localparam int ST_HALF    = 2;
  localparam int ST_OVF     = 4;
  localparam int ST_LVL_LSB = 8;
endpackage

// File: rtl/audio_tx_fifo_ram.sv
module audio_tx_fifo_ram #(
  parameter int DW = 24,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/audio_tx_fifo_ctr.sv
module audio_tx_fifo_ctr #(
  parameter int TOTAL  = 256,
  parameter int MAX_CH = 8,
  localparam int PTR_W = $clog2(TOTAL),
  localparam int CNT_W = PTR_W + 1,
  localparam int CH_W  = $clog2(MAX_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [CH_W-1:0]  chan_m1,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] frames,
  output logic [CNT_W-1:0] cap_frames,
  output logic             full,
  output logic             empty,
  output logic             half_low
);
  logic [CNT_W-1:0] cap_tbl [MAX_CH];
  logic [CH_W-1:0]  rem;
  logic [CNT_W-1:0] half_f;

  for (genvar g = 0; g < MAX_CH; g++) begin : g_cap
    assign cap_tbl[g] = CNT_W'(TOTAL >> $clog2(g + 1));
  end

  assign cap_frames = cap_tbl[chan_m1];
  assign half_f     = cap_frames >> 1;
  assign full       = (frames == cap_frames);
  assign empty      = (frames == '0) && (rem == '0);
  assign half_low   = (frames < half_f) || ((frames == half_f) && (rem == '0));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      frames <= '0;
      rem    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      unique case ({push, pop})
        2'b10: begin
          if (rem == chan_m1) begin
            rem    <= '0;
            frames <= frames + 1'b1;
          end else begin
            rem <= rem + 1'b1;
          end
        end
        2'b01: begin
          if (rem == '0) begin
            rem    <= chan_m1;
            frames <= frames - 1'b1;
          end else begin
            rem <= rem - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_fifo_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int TOTAL  = 256,
  parameter int MAX_CH = 8,
  parameter int ADDR_W = 4,
  localparam int PTR_W = $clog2(TOTAL),
  localparam int CNT_W = PTR_W + 1,
  localparam int CH_W  = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CH_W-1:0]   chan_m1,
  input  logic              ser_pop,
  output logic [DATA_W-1:0] ser_data,
  output logic              irq
);
  logic ctrl_wr, stat_wr, data_wr;
  logic clr_pend, half_en, ovf_q, unf_q, pend_q, below_q;
  logic full, empty, half_low;
  logic do_push, do_pop, ovf_evt, unf_evt, half_evt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] frames, cap_frames;
  logic [31:0] ctrl_word, stat_word, rd_word;
  logic unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign data_wr = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));

  assign do_push  = data_wr && !full && !clr_pend;
  assign do_pop   = ser_pop && !empty && !clr_pend;
  assign ovf_evt  = data_wr && full && !clr_pend;
  assign unf_evt  = ser_pop && empty && !clr_pend;
  assign half_evt = half_en && half_low && !below_q;

  assign unused_wbits = ^reg_wdata[31:DATA_W];

  audio_tx_fifo_ctr #(.TOTAL(TOTAL), .MAX_CH(MAX_CH)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_pend),
    .push      (do_push),
    .pop       (do_pop),
    .chan_m1   (chan_m1),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .frames    (frames),
    .cap_frames(cap_frames),
    .full      (full),
    .empty     (empty),
    .half_low  (half_low)
  );

  audio_tx_fifo_ram #(.DW(DATA_W), .AW(PTR_W)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (do_push),
    .waddr(wr_ptr),
    .wdata(reg_wdata[DATA_W-1:0]),
    .re   (do_pop),
    .raddr(rd_ptr),
    .rdata(ser_data)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_CLR]     = clr_pend;
    ctrl_word[CTRL_HALF_EN] = half_en;
    stat_word = '0;
    stat_word[ST_LVL_LSB +: CNT_W] = frames;
    stat_word[ST_OVF]  = ovf_q;
    stat_word[ST_HALF] = pend_q;
    stat_word[ST_UNF]  = unf_q;
    if (reg_addr == ADDR_W'(OFS_CTRL))      rd_word = ctrl_word;
    else if (reg_addr == ADDR_W'(OFS_STAT)) rd_word = stat_word;
    else                                    rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_pend  <= 1'b0;
      half_en   <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      pend_q    <= 1'b0;
      below_q   <= 1'b1;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        half_en  <= reg_wdata[CTRL_HALF_EN];
        clr_pend <= reg_wdata[CTRL_CLR];
      end else begin
        clr_pend <= 1'b0;
      end
      below_q <= half_low;
      ovf_q  <= (ovf_q  && !(stat_wr && !reg_wdata[ST_OVF]))  || ovf_evt;
      unf_q  <= (unf_q  && !(stat_wr && !reg_wdata[ST_UNF]))  || unf_evt;
      pend_q <= (pend_q && !(stat_wr && !reg_wdata[ST_HALF])) || half_evt;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  assign irq = pend_q;
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic             stat_wr,
  input logic             data_wr,
  input logic             ser_pop,
  input logic             clr_pend,
  input logic             full,
  input logic             empty,
  input logic             do_push,
  input logic             do_pop,
  input logic             ovf_q,
  input logic             unf_q,
  input logic             irq,
  input logic [CNT_W-1:0] frames,
  input logic [CNT_W-1:0] cap_frames
);
  // R1: level never passes the frame limit
  a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
    frames <= cap_frames);

  // R4: a write into a full FIFO leaves the level alone and flags overflow
  a_r4_drop_full: assert property (@(posedge clk) disable iff (rst)
    (data_wr && full && !ser_pop && !clr_pend) |=> ($stable(frames) && ovf_q));

  // R5: popping an empty FIFO flags underflow
  a_r5_underflow: assert property (@(posedge clk) disable iff (rst)
    (ser_pop && empty && !clr_pend) |=> unf_q);

  // R6: overflow flag holds until a status write
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !stat_wr) |=> ovf_q);

  // R7: clear lasts one cycle and leaves the FIFO empty
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && !ctrl_wr) |=> (!clr_pend && empty));

  // R8: request holds until acknowledged
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_wr) |=> irq);

  // R10: simultaneous push and pop keep the frame count
  a_r10_push_pop: assert property (@(posedge clk) disable iff (rst)
    (do_push && do_pop) |=> $stable(frames));
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_wr   (ctrl_wr),
  .stat_wr   (stat_wr),
  .data_wr   (data_wr),
  .ser_pop   (ser_pop),
  .clr_pend  (clr_pend),
  .full      (full),
  .empty     (empty),
  .do_push   (do_push),
  .do_pop    (do_pop),
  .ovf_q     (ovf_q),
  .unf_q     (unf_q),
  .irq       (irq),
  .frames    (frames),
  .cap_frames(cap_frames)
);

// File: tb/audio_tx_fifo_tb.sv
module audio_tx_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, ser_pop = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  chan_m1 = '0;
  logic [23:0] ser_data;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_tx_fifo u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_m1(chan_m1), .ser_pop(ser_pop), .ser_data(ser_data), .irq(irq)
  );

  function automatic void check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic int cap_of(int ch);
    if (ch == 1) return 256;
    if (ch == 2) return 128;
    if (ch <= 4) return 64;
    return 32;
  endfunction

  // behavioural reference model
  int q[$];
  bit started = 0;
  bit en_m, clrp_m, ovf_m, unf_m, pend_m, belowq_m;
  int pop_m, rdata_m;

  always @(posedge clk) begin
    bit was_rd;
    was_rd = 0;
    if (rst) begin
      q.delete(); en_m = 0; clrp_m = 0; ovf_m = 0; unf_m = 0; pend_m = 0;
      belowq_m = 1; pop_m = 0; rdata_m = 0; started = 1;
    end else begin
      int ch, sz, cp;
      bit fullm, emptym, below, cw, sw, dw, pset, oset, uset, pushok, popok, clr_old;
      ch = int'(chan_m1) + 1; sz = q.size(); cp = cap_of(ch) * ch;
      fullm = (sz == cp); emptym = (sz == 0); below = (2 * sz <= cp);
      cw = reg_wr && reg_addr == 4'h0; sw = reg_wr && reg_addr == 4'h4; dw = reg_wr && reg_addr == 4'h8;
      if (reg_rd) begin
        was_rd = 1;
        if (reg_addr == 4'h0)      rdata_m = (int'(en_m) << 20) | int'(clrp_m);
        else if (reg_addr == 4'h4) rdata_m = ((sz / ch) << 8) | (int'(ovf_m) << 4) | (int'(pend_m) << 2) | int'(unf_m);
        else                       rdata_m = 0;
      end
      pset = en_m && below && !belowq_m; belowq_m = below;
      oset = dw && fullm && !clrp_m; uset = ser_pop && emptym && !clrp_m;
      pushok = dw && !fullm && !clrp_m; popok = ser_pop && !emptym && !clrp_m;
      ovf_m  = (ovf_m  && !(sw && !reg_wdata[4])) || oset;
      unf_m  = (unf_m  && !(sw && !reg_wdata[0])) || uset;
      pend_m = (pend_m && !(sw && !reg_wdata[2])) || pset;
      clr_old = clrp_m;
      if (cw) begin en_m = reg_wdata[20]; clrp_m = reg_wdata[0]; end
      else clrp_m = 0;
      if (clr_old) q.delete();
      else begin
        if (popok) pop_m = q.pop_front();
        if (pushok) q.push_back(int'(reg_wdata & 32'h00FF_FFFF));
      end
    end
    #2;
    if (started && !done) begin
      check("R8 irq vs model", int'(irq), int'(pend_m));
      check("R3 ser_data vs model", int'(ser_data), pop_m);
      if (was_rd) check("R9 reg_rdata vs model", int'(reg_rdata), rdata_m);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = int'(reg_rdata);
  endtask

  task automatic pop1();
    ser_pop = 1;
    @(negedge clk);
    ser_pop = 0;
  endtask

  task automatic push_pop(input logic [31:0] d);
    reg_wr = 1; reg_addr = 4'h8; reg_wdata = d; ser_pop = 1;
    @(negedge clk);
    reg_wr = 0; ser_pop = 0;
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) wr(4'h8, 32'hAB00_0000 | 32'(base + i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    rd(4'h4, v); check("R9 status after reset", v, 0);
    rd(4'h0, v); check("R9 ctrl after reset", v, 0);
    check("R9 irq after reset", int'(irq), 0);
    rd(4'h8, v); check("R9 data offset reads zero", v, 0);

    // one channel: limit, overflow, drain, half request, underflow
    chan_m1 = 3'd0;
    fill(256, 0);
    rd(4'h4, v); check("R1 one channel full at 256 frames", v, 32'h1_0000);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R4 overflow on full write", v, 32'h1_0010);
    wr(4'h0, 32'h0010_0000);
    rd(4'h0, v); check("R9 ctrl readback enable", v, 32'h0010_0000);
    for (int i = 0; i < 127; i++) pop1();
    @(negedge clk);
    check("R8 no request above half", int'(irq), 0);
    pop1();
    @(negedge clk);
    check("R8 request at half", int'(irq), 1);
    for (int i = 0; i < 128; i++) pop1();
    check("R3 last sample masked", int'(ser_data), 32'h0000_00FF);
    pop1();
    check("R5 data held on empty pop", int'(ser_data), 32'h0000_00FF);
    rd(4'h4, v); check("R5 underflow flag", v, 32'h15);
    wr(4'h4, 32'h14);
    rd(4'h4, v); check("R6 selective flag clear", v, 32'h14);
    check("R8 irq held through other clears", int'(irq), 1);
    wr(4'h4, 32'h0);
    rd(4'h4, v); check("R6 all flags cleared", v, 0);
    check("R8 irq released", int'(irq), 0);

    // three channels: partial frames, limit, push+pop
    chan_m1 = 3'd2;
    fill(5, 16);
    rd(4'h4, v); check("R2 partial frame rounds down", v, 32'h100);
    fill(1, 32);
    rd(4'h4, v); check("R2 two whole frames", v, 32'h200);
    fill(186, 40);
    rd(4'h4, v); check("R1 three channels full at 64", v, 32'h4000);
    wr(4'h8, 32'h1234);
    rd(4'h4, v); check("R4 overflow three channels", v, 32'h4010);
    for (int i = 0; i < 3; i++) pop1();
    push_pop(32'h777); push_pop(32'h888);
    rd(4'h4, v); check("R10 push and pop keep level", v, 32'h3F10);

    // clear behaviour
    wr(4'h0, 32'h1);
    rd(4'h0, v); check("R7 clear bit visible one cycle", v, 1);
    rd(4'h0, v); check("R7 clear bit self-clears", v, 0);
    rd(4'h4, v); check("R7 emptied, flags kept", v, 32'h10);
    wr(4'h0, 32'h1);
    wr(4'h8, 32'h55);
    rd(4'h4, v); check("R7 write in clear cycle dropped", v, 32'h10);
    wr(4'h4, 32'h0);

    // eight then five channels
    chan_m1 = 3'd7;
    fill(257, 100);
    rd(4'h4, v); check("R1 eight channels full at 32", v, 32'h2010);
    wr(4'h0, 32'h1);
    @(negedge clk);
    wr(4'h4, 32'h0);
    chan_m1 = 3'd4;
    fill(160, 500);
    rd(4'h4, v); check("R1 five channels full at 32", v, 32'h2000);
    wr(4'h8, 32'h9);
    rd(4'h4, v); check("R4 overflow five channels", v, 32'h2010);
    for (int i = 0; i < 4; i++) pop1();
    check("R3 fifo order five channels", int'(ser_data), 32'h0000_01F7);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule